// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the slave side of a three-wire serial memory bus (select, serial clock, data in, with a separate data out). It holds a 512-byte register array that can be read as 8-bit or 16-bit words. A static organisation input chooses the word width. A host frames each command as a start bit, a two-bit opcode, an address field and, for writes, a data field. The host then reads the result back on the data-out line.

The block is synchronous to a fast system clock. It oversamples the serial clock and acts on each rising edge it sees while select is high. A write-enable latch guards every command that changes the array: word write, word erase, erase-all and write-all. The latch starts out disabled and does not affect reads. A read stream keeps running, word after word, for as long as select stays high. A parallel test port lets the array be preloaded.

Top module: `mw_serial_mem`

## Requirements
- R1: After reset the write-enable latch is disabled and `do_en_o` is 0. While the latch is disabled, write, erase, erase-all and write-all frames leave the array unchanged.
- R2: Opcode 00 with the first two address-field bits 11 sets the latch. Opcode 00 with 00 clears it. The latch changes only on a serial clock rising edge and otherwise holds its value.
- R3: A read returns the stored data whether the latch is set or clear.
- R4: Bits on `di_i` are taken on serial clock rising edges. Zeros before the start bit (a 1) are ignored. Then come the opcode (10 read, 01 write, 11 erase, 00 latch and whole-array group) and the address field, MSB first. The address field is 9 bits when `org_i`=0 and 8 bits when `org_i`=1.
- R5: In a read, the rising edge that takes the last address bit drives `do_o`=0 with `do_en_o`=1 (the dummy bit). Each following rising edge presents the next data bit, MSB first: 8 bits when `org_i`=0, 16 bits when `org_i`=1. `do_o` changes only after a serial clock rising edge or when select is low.
- R6: With select held high, the next word follows the last bit of the current word with no dummy bit. The address wraps from 511 (8-bit) or 255 (16-bit) to 0.
- R7: `do_en_o` is 0 while a command is shifted in, and it is 0 one system clock after select goes low.
- R8: Dropping select aborts the frame, and the next start bit begins a new frame. The latch keeps its value.
- R9: Opcode 01 takes 8 or 16 data bits, MSB first, after the address. It stores them when the latch is set. 16-bit word a is held as byte 2a (bits 15:8) and byte 2a+1 (bits 7:0).
- R10: Opcode 11 sets the addressed word to all ones. Sub-command 10 in the 00 group sets every word to all ones. Sub-command 01 in the 00 group writes the data field that follows to every word. All three need the latch set.
- R11: When `tp_we_i` is high, `tp_wdata_i` is written to byte `tp_addr_i` on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| org_i | input | 1 | Word width select: 0 = 8-bit, 1 = 16-bit |
| cs_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out |
| do_en_o | output | 1 | Data-out drive enable (0 = high impedance) |
| tp_we_i | input | 1 | Test port byte write strobe |
| tp_addr_i | input | 9 | Test port byte address |
| tp_wdata_i | input | 8 | Test port byte data |

## Verification
The hardest behaviour to reach is the wrap of a sequential read. After the last location, the stream must go straight on to location 0 with no dummy bit and no new command. The bench preloads a distinct value into every byte through the test port. It then opens reads at the last address in each organisation and keeps select high across two words, so the wrapped word can be told apart. Locked writes are a second blind spot, because nothing changes at the outputs. They are exposed by a read of the target location after a write frame sent with the latch disabled.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  // sub-commands in the 00 group (first two address bits)
  localparam logic [1:0] SUB_LOCK  = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_ERALL = 2'b10;
  localparam logic [1:0] SUB_OPEN  = 2'b11;
endpackage

// File: rtl/mw_edge_det.sv
module mw_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/mw_mem_array.sv
module mw_mem_array #(
  parameter int DEPTH = 512,
  parameter int BW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int WW   = 2 * BW
) (
  input  logic          clk_i,
  input  logic          org_i,
  input  logic          tp_we_i,
  input  logic [AW-1:0] tp_addr_i,
  input  logic [BW-1:0] tp_wdata_i,
  input  logic          cmd_we_i,
  input  logic          cmd_all_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [WW-1:0] cmd_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [WW-1:0] rd_word_o
);
  logic [BW-1:0] mem_q [DEPTH];
  logic [BW-1:0] hi, lo;
  logic [AW-1:0] cmd_even, rd_even;

  assign hi       = cmd_data_i[WW-1:BW];
  assign lo       = cmd_data_i[BW-1:0];
  assign cmd_even = {cmd_addr_i[AW-2:0], 1'b0};
  assign rd_even  = {rd_addr_i[AW-2:0], 1'b0};

  always_ff @(posedge clk_i) begin
    if (tp_we_i) begin
      mem_q[tp_addr_i] <= tp_wdata_i;
    end else if (cmd_we_i) begin
      if (cmd_all_i) begin
        for (int i = 0; i < DEPTH; i++)
          mem_q[i] <= (org_i && (i % 2 == 0)) ? hi : lo;
      end else if (org_i) begin
        mem_q[cmd_even]        <= hi;
        mem_q[cmd_even | AW'(1)] <= lo;
      end else begin
        mem_q[cmd_addr_i] <= lo;
      end
    end
  end

  // word left-aligned so the MSB is always bit WW-1
  assign rd_word_o = org_i ? {mem_q[rd_even], mem_q[rd_even | AW'(1)]}
                           : {mem_q[rd_addr_i], {BW{1'b0}}};
endmodule

// File: rtl/mw_serial_mem.sv
module mw_serial_mem
  import mw_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int BW    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     org_i,
  input  logic                     cs_i,
  input  logic                     sclk_i,
  input  logic                     di_i,
  output logic                     do_o,
  output logic                     do_en_o,
  input  logic                     tp_we_i,
  input  logic [$clog2(DEPTH)-1:0] tp_addr_i,
  input  logic [BW-1:0]            tp_wdata_i
);
  localparam int AW = $clog2(DEPTH);
  localparam int WW = 2 * BW;
  localparam int CW = $clog2(WW + 1);

  logic          sclk_rise, rise;
  mw_state_e     state_q;
  logic [CW-1:0] cnt_q, alen, dlen;
  logic [1:0]    op_q, sub;
  logic [AW-1:0] addr_q, addr_nx, addr_inc;
  logic [WW-1:0] dsh_q, rsh_q, wdata_nx, rd_word;
  logic          wen_q, do_q, oe_q;
  logic          m_we_q, m_all_q;
  logic [AW-1:0] m_addr_q;
  logic [WW-1:0] m_data_q;

  mw_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sclk_i),
    .rise_o(sclk_rise)
  );

  assign rise     = sclk_rise & cs_i;
  assign alen     = org_i ? CW'(AW - 1) : CW'(AW);
  assign dlen     = org_i ? CW'(WW) : CW'(BW);
  assign addr_nx  = {addr_q[AW-2:0], di_i};
  assign sub      = org_i ? addr_nx[AW-2 -: 2] : addr_nx[AW-1 -: 2];
  assign addr_inc = org_i ? {1'b0, addr_q[AW-2:0] + (AW-1)'(1)} : addr_q + AW'(1);
  assign wdata_nx = {dsh_q[WW-2:0], di_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      dsh_q    <= '0;
      rsh_q    <= '0;
      wen_q    <= 1'b0;
      do_q     <= 1'b0;
      oe_q     <= 1'b0;
      m_we_q   <= 1'b0;
      m_all_q  <= 1'b0;
      m_addr_q <= '0;
      m_data_q <= '0;
    end else begin
      m_we_q  <= 1'b0;
      m_all_q <= 1'b0;
      if (!cs_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        do_q    <= 1'b0;
      end else if (rise) begin
        unique case (state_q)
          ST_IDLE: if (di_i) begin
            state_q <= ST_OP;
            cnt_q   <= '0;
            addr_q  <= '0;
          end
          ST_OP: begin
            op_q <= {op_q[0], di_i};
            if (cnt_q == CW'(1)) begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + CW'(1);
          end
          ST_ADDR: begin
            addr_q <= addr_nx;
            cnt_q  <= cnt_q + CW'(1);
            if (cnt_q == alen - CW'(1)) begin
              cnt_q    <= '0;
              state_q  <= ST_DONE;
              m_addr_q <= addr_nx;
              m_data_q <= '1;
              unique case (op_q)
                OP_READ: begin
                  state_q <= ST_READ;
                  do_q    <= 1'b0;
                  oe_q    <= 1'b1;
                end
                OP_WRITE: state_q <= ST_DATA;
                OP_ERASE: m_we_q  <= wen_q;
                default: unique case (sub)
                  SUB_OPEN:  wen_q   <= 1'b1;
                  SUB_LOCK:  wen_q   <= 1'b0;
                  SUB_WRALL: state_q <= ST_DATA;
                  default: begin
                    m_we_q  <= wen_q;
                    m_all_q <= 1'b1;
                  end
                endcase
              endcase
            end
          end
          ST_DATA: begin
            dsh_q <= wdata_nx;
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == dlen - CW'(1)) begin
              state_q  <= ST_DONE;
              m_we_q   <= wen_q;
              m_all_q  <= (op_q == OP_EXT);
              m_data_q <= wdata_nx;
            end
          end
          ST_READ: begin
            if (cnt_q == '0) begin
              do_q  <= rd_word[WW-1];
              rsh_q <= rd_word << 1;
            end else begin
              do_q  <= rsh_q[WW-1];
              rsh_q <= rsh_q << 1;
            end
            if (cnt_q == dlen - CW'(1)) begin
              cnt_q  <= '0;
              addr_q <= addr_inc;
            end else cnt_q <= cnt_q + CW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  mw_mem_array #(.DEPTH(DEPTH), .BW(BW)) u_mem (
    .clk_i     (clk_i),
    .org_i     (org_i),
    .tp_we_i   (tp_we_i),
    .tp_addr_i (tp_addr_i),
    .tp_wdata_i(tp_wdata_i),
    .cmd_we_i  (m_we_q),
    .cmd_all_i (m_all_q),
    .cmd_addr_i(m_addr_q),
    .cmd_data_i(m_data_q),
    .rd_addr_i (addr_q),
    .rd_word_o (rd_word)
  );

  assign do_o    = do_q;
  assign do_en_o = oe_q;
endmodule

// File: rtl/mw_serial_mem_chk.sv
module mw_serial_mem_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic sclk_rise_i,
  input logic do_i,
  input logic do_en_i,
  input logic wen_i
);
  assert_hiz_cs_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs_i) |-> !do_en_i);

  assert_dummy_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(do_en_i) |-> !do_i);

  assert_do_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_i != $past(do_i)) |-> ($past(sclk_rise_i) || !$past(cs_i)));

  assert_oe_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(do_en_i) |-> $past(sclk_rise_i));

  assert_wen_on_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i != $past(wen_i)) |-> $past(sclk_rise_i));
endmodule

bind mw_serial_mem mw_serial_mem_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .sclk_rise_i(rise),
  .do_i       (do_o),
  .do_en_i    (do_en_o),
  .wen_i      (wen_q)
);

// File: tb/tb_mw_serial_mem.sv
`timescale 1ns/1ps
module tb_mw_serial_mem;
  logic clk = 1'b0, rst_n = 1'b0;
  logic org = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic do_o, do_en;
  logic tp_we = 1'b0;
  logic [8:0] tp_addr = '0;
  logic [7:0] tp_wdata = '0;
  logic [7:0] model [512];
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mw_serial_mem dut (
    .clk_i(clk), .rst_ni(rst_n), .org_i(org), .cs_i(cs), .sclk_i(sclk),
    .di_i(di), .do_o(do_o), .do_en_o(do_en),
    .tp_we_i(tp_we), .tp_addr_i(tp_addr), .tp_wdata_i(tp_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic oe, output logic d);
    @(negedge clk); di = b; sclk = 1'b1;
    repeat (4) @(negedge clk);
    oe = do_en; d = do_o; sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk); cs = 1'b0; di = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int alen(input logic o); return o ? 8 : 9; endfunction
  function automatic int dlen(input logic o); return o ? 16 : 8; endfunction

  function automatic int exp_word(input logic o, input int a);
    return o ? {model[2*a], model[2*a+1]} : int'(model[a]);
  endfunction

  // header: start, opcode, address; returns any drive seen and last-bit outputs
  task automatic header(input logic o, input logic [1:0] op, input int addr,
                        output bit oe_seen, output logic oe_last, output logic d_last);
    logic oe, d;
    @(negedge clk); org = o; cs = 1'b1;
    oe_seen = 1'b0;
    sbit(1'b0, oe, d); oe_seen |= oe;
    sbit(1'b1, oe, d); oe_seen |= oe;
    sbit(op[1], oe, d); oe_seen |= oe;
    sbit(op[0], oe, d); oe_seen |= oe;
    for (int i = alen(o) - 1; i >= 1; i--) begin
      sbit(logic'((addr >> i) & 1), oe, d); oe_seen |= oe;
    end
    sbit(logic'(addr & 1), oe_last, d_last);
  endtask

  task automatic send_cmd(input logic o, input logic [1:0] op, input int addr,
                          input int data, input bit has_data);
    bit s; logic a, b;
    header(o, op, addr, s, a, b);
    if (has_data)
      for (int i = dlen(o) - 1; i >= 0; i--) sbit(logic'((data >> i) & 1), a, b);
    cs_low();
  endtask

  function automatic int sub_addr(input logic o, input logic [1:0] sub);
    return int'(sub) << (alen(o) - 2);
  endfunction

  task automatic read_seq(input logic o, input int addr, input int nw, input string req);
    bit seen; logic oe, d;
    int a = addr;
    header(o, 2'b10, addr, seen, oe, d);
    chk(!seen, "R7", "drive during command", int'(seen), 0);
    chk(oe === 1'b1 && d === 1'b0, "R5", "dummy bit oe/do", {oe, d}, 2'b10);
    for (int w = 0; w < nw; w++) begin
      int got = 0;
      for (int i = 0; i < dlen(o); i++) begin
        sbit(1'b0, oe, d);
        got = (got << 1) | int'(d);
      end
      chk(got == exp_word(o, a), req, $sformatf("word @%0d", a), got, exp_word(o, a));
      a = (a + 1) % (o ? 256 : 512);
    end
    cs_low();
  endtask

  task automatic model_write(input logic o, input int a, input int d);
    if (o) begin model[2*a] = 8'(d >> 8); model[2*a+1] = 8'(d); end
    else model[a] = 8'(d);
  endtask

  task automatic t_reset();
    chk(do_en === 1'b0, "R1", "do_en after reset", int'(do_en), 0);
    chk(do_o === 1'b0, "R1", "do after reset", int'(do_o), 0);
  endtask

  task automatic t_preload();
    for (int i = 0; i < 512; i++) begin
      @(negedge clk); tp_we = 1'b1; tp_addr = 9'(i); tp_wdata = 8'((i * 37 + 5) ^ (i >> 3));
      model[i] = tp_wdata;
    end
    @(negedge clk); tp_we = 1'b0;
    read_seq(1'b0, 100, 1, "R11");
  endtask

  task automatic t_reads();
    read_seq(1'b0, 5, 1, "R3");
    read_seq(1'b1, 3, 1, "R5");
    read_seq(1'b0, 510, 3, "R6");
    read_seq(1'b1, 255, 2, "R6");
  endtask

  task automatic t_write_locked();
    send_cmd(1'b0, 2'b01, 20, 8'h3c, 1'b1);
    read_seq(1'b0, 20, 1, "R1");
    send_cmd(1'b0, 2'b11, 21, 0, 1'b0);
    read_seq(1'b0, 21, 1, "R1");
  endtask

  task automatic t_enable_write();
    send_cmd(1'b0, 2'b00, sub_addr(1'b0, 2'b11), 0, 1'b0);
    send_cmd(1'b0, 2'b01, 20, 8'h3c, 1'b1);
    model_write(1'b0, 20, 8'h3c);
    read_seq(1'b0, 20, 1, "R9");
    send_cmd(1'b1, 2'b01, 30, 16'hbeef, 1'b1);
    model_write(1'b1, 30, 16'hbeef);
    read_seq(1'b1, 30, 1, "R9");
    read_seq(1'b0, 61, 1, "R9");
    read_seq(1'b0, 7, 1, "R3");
  endtask

  task automatic t_abort();
    bit s; logic oe, d;
    header(1'b0, 2'b10, 9, s, oe, d);
    sbit(1'b0, oe, d);
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    chk(do_en === 1'b0, "R7", "do_en after select low", int'(do_en), 0);
    repeat (2) @(negedge clk);
    @(negedge clk); cs = 1'b1;
    sbit(1'b1, oe, d); sbit(1'b0, oe, d);
    cs_low();
    chk(do_en === 1'b0, "R8", "no drive after aborted frame", int'(do_en), 0);
    send_cmd(1'b0, 2'b01, 40, 8'h77, 1'b1);
    model_write(1'b0, 40, 8'h77);
    read_seq(1'b0, 40, 1, "R8");
  endtask

  task automatic t_erase_wrall();
    send_cmd(1'b0, 2'b11, 7, 0, 1'b0);
    model[7] = 8'hff;
    read_seq(1'b0, 7, 1, "R10");
    send_cmd(1'b1, 2'b00, sub_addr(1'b1, 2'b10), 0, 1'b0);
    for (int i = 0; i < 512; i++) model[i] = 8'hff;
    read_seq(1'b1, 100, 2, "R10");
    send_cmd(1'b0, 2'b00, sub_addr(1'b0, 2'b01), 8'h5a, 1'b1);
    for (int i = 0; i < 512; i++) model[i] = 8'h5a;
    read_seq(1'b0, 0, 2, "R10");
    send_cmd(1'b1, 2'b00, sub_addr(1'b1, 2'b01), 16'hc381, 1'b1);
    for (int i = 0; i < 256; i++) model_write(1'b1, i, 16'hc381);
    read_seq(1'b1, 77, 1, "R10");
  endtask

  task automatic t_disable();
    send_cmd(1'b0, 2'b00, sub_addr(1'b0, 2'b00), 0, 1'b0);
    send_cmd(1'b0, 2'b01, 1, 8'h11, 1'b1);
    read_seq(1'b0, 1, 1, "R2");
    send_cmd(1'b1, 2'b00, sub_addr(1'b1, 2'b10), 0, 1'b0);
    read_seq(1'b1, 4, 1, "R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_preload();
    t_reads();
    t_write_locked();
    t_enable_write();
    t_abort();
    t_erase_wrall();
    t_disable();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule